// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous SRAM

This block is a synchronous memory with a dedicated read port and a dedicated write port that share a single address bus. Every access moves two words: the word at the requested address and the word at the next address, which wraps from the top of the array to entry zero. The array is a small register memory whose depth is set by the address width parameter.

A read is started by a low read select on a rising clock edge, which also captures the read address. A write is started by a low write select on a rising edge, which captures the first data word and its lane masks. The falling edge that follows captures the write address, the second data word and its lane masks. Read data comes back in the next cycle. The first word is presented while the clock is high, and the second while it is low. When no read is pending, the output enable drops and the data bus reads zero. A read always returns the freshest contents of a location, including a write issued in the same cycle or in the cycle before.

The output clock pair is taken to be phase-aligned with the input clock, so all timing is referenced to `clk`.

Top module: `qdrb2_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read, `rd_oe` is 0 and `rdata` is all zeros. The array starts cleared.
- R2: If `rd_sel_n` is low at rising edge t, `rd_oe` is 1 from rising edge t+1 until rising edge t+2. While `clk` is high during that interval, `rdata` holds the word at the read address.
- R3: While `clk` is low in the same cycle, `rdata` holds the word at the read address plus one, modulo the depth.
- R4: A write takes its first word and masks at the rising edge where `wr_sel_n` is low. It takes the address, second word and masks at the following falling edge. The first word goes to that address and the second word to the address plus one.
- R5: `bw_n` is active-low, with one bit per 9-bit lane (bit 0 for bits 8:0, bit 1 for bits 17:9), and is sampled separately with each word. A lane whose bit is high keeps its stored value.
- R6: A read returns the newest data for each location, including a write started at the same rising edge or at the previous one.
- R7: If `rd_sel_n` is high at rising edge t, `rd_oe` is 0 and `rdata` is zero from rising edge t+1 until rising edge t+2.
- R8: A deselected port ignores its address and data. An idle write port leaves the array unchanged. Activity on one port does not alter the other port's results.
- R9: A burst that starts at the last address places its second word at address 0, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. A rising edge starts accesses; a falling edge takes the second write half |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read start |
| wr_sel_n | input | 1 | Active-low write start |
| addr | input | AW (4) | Shared address: read address on the rising edge, write address on the falling edge |
| wdata | input | 18 | Write data, first word on the rising edge and second on the falling edge |
| bw_n | input | 2 | Active-low lane write masks, one set per data word |
| rdata | output | 18 | Read data: first word while clk is high, second while low |
| rd_oe | output | 1 | High while read data is driven |

## Verification
The hardest case to reach is a collision between a write still waiting to commit and a read of one of its two locations. This includes the case where only some lanes of that write are enabled, so the returned word mixes old and new bytes. Directed cycles issue a read and a write to the same address at one rising edge, and a write followed directly by a read of it, with partial lane masks. The random phase confines many addresses to a window of four entries, so overlapping bursts, half-masked words and wrap-around at the top address occur often.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;
    localparam int LANE_BITS = 9;

    typedef enum logic {
        BEAT_LO = 1'b0,
        BEAT_HI = 1'b1
    } beat_e;
endpackage

// File: rtl/qdrb2_wr_stage.sv
module qdrb2_wr_stage
    import qdrb2_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2,
    localparam int W    = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] bw_n,
    output logic             commit,
    output logic [AW-1:0]    c_addr,
    output logic [W-1:0]     c_d0,
    output logic [LANES-1:0] c_be0,
    output logic [W-1:0]     c_d1,
    output logic [LANES-1:0] c_be1
);
    typedef struct packed {
        logic             start;
        logic [W-1:0]     d0;
        logic [LANES-1:0] be0;
    } rise_t;

    typedef struct packed {
        logic             half;
        logic [AW-1:0]    a;
        logic [W-1:0]     d1;
        logic [LANES-1:0] be1;
    } fall_t;

    rise_t rise_d, rise_q;
    fall_t fall_d, fall_q;

    always_comb begin
        rise_d       = rise_q;
        rise_d.start = !wr_sel_n;
        if (!wr_sel_n) begin
            rise_d.d0  = wdata;
            rise_d.be0 = ~bw_n;
        end
        fall_d      = fall_q;
        fall_d.half = rise_q.start;
        if (rise_q.start) begin
            fall_d.a   = addr;
            fall_d.d1  = wdata;
            fall_d.be1 = ~bw_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign commit = fall_q.half;
    assign c_addr = fall_q.a;
    assign c_d0   = rise_q.d0;
    assign c_be0  = rise_q.be0;
    assign c_d1   = fall_q.d1;
    assign c_be1  = fall_q.be1;

    // R4
    commit_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!wr_sel_n));
endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array
    import qdrb2_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2,
    localparam int W     = LANES * LANE_BITS,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [AW-1:0]    c_addr,
    input  logic [W-1:0]     c_d0,
    input  logic [LANES-1:0] c_be0,
    input  logic [W-1:0]     c_d1,
    input  logic [LANES-1:0] c_be1,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rword_lo,
    output logic [W-1:0]     rword_hi
);
    logic [W-1:0]  mem_d [DEPTH];
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] c_addr_nx;
    logic [AW-1:0] raddr_nx;

    assign c_addr_nx = AW'(c_addr + 1'b1);
    assign raddr_nx  = AW'(raddr + 1'b1);

    function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                                input logic [W-1:0] new_w,
                                                input logic [LANES-1:0] en);
        logic [W-1:0] r;
        r = old_w;
        for (int l = 0; l < LANES; l++)
            if (en[l]) r[l*LANE_BITS +: LANE_BITS] = new_w[l*LANE_BITS +: LANE_BITS];
        return r;
    endfunction

    function automatic logic [W-1:0] fresh(input logic [AW-1:0] a,
                                           input logic [W-1:0] stored);
        logic [W-1:0] r;
        r = stored;
        if (commit && a == c_addr)    r = lane_merge(r, c_d0, c_be0);
        if (commit && a == c_addr_nx) r = lane_merge(r, c_d1, c_be1);
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = fresh(AW'(i), mem_q[i]);
        rword_lo = fresh(raddr, mem_q[raddr]);
        rword_hi = fresh(raddr_nx, mem_q[raddr_nx]);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    // R8
    idle_keeps_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem_q[DEPTH-1]));
endmodule

// File: rtl/qdrb2_rd_pipe.sv
module qdrb2_rd_pipe
    import qdrb2_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2,
    localparam int W    = LANES * LANE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_sel_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] raddr,
    input  logic [W-1:0]  rword_lo,
    input  logic [W-1:0]  rword_hi,
    output logic [W-1:0]  rdata,
    output logic          rd_oe
);
    typedef struct packed {
        logic          go;
        logic [AW-1:0] a;
        logic          valid;
        logic [W-1:0]  w_lo;
        logic [W-1:0]  w_hi;
    } rd_t;

    rd_t   st_d, st_q;
    beat_e beat;

    always_comb begin
        st_d       = st_q;
        st_d.go    = !rd_sel_n;
        if (!rd_sel_n) st_d.a = addr;
        st_d.valid = st_q.go;
        if (st_q.go) begin
            st_d.w_lo = rword_lo;
            st_d.w_hi = rword_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat  = clk ? BEAT_LO : BEAT_HI;
    assign raddr = st_q.a;
    assign rd_oe = st_q.valid;
    assign rdata = !st_q.valid ? '0 : (beat == BEAT_LO ? st_q.w_lo : st_q.w_hi);
endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram
    import qdrb2_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 2,
    localparam int W    = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] bw_n,
    output logic [W-1:0]     rdata,
    output logic             rd_oe
);
    logic             commit;
    logic [AW-1:0]    c_addr;
    logic [W-1:0]     c_d0, c_d1;
    logic [LANES-1:0] c_be0, c_be1;
    logic [AW-1:0]    raddr;
    logic [W-1:0]     rword_lo, rword_hi;

    qdrb2_wr_stage #(.AW(AW), .LANES(LANES)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .addr(addr),
        .wdata(wdata), .bw_n(bw_n), .commit(commit), .c_addr(c_addr),
        .c_d0(c_d0), .c_be0(c_be0), .c_d1(c_d1), .c_be1(c_be1)
    );

    qdrb2_array #(.AW(AW), .LANES(LANES)) u_mem (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr),
        .c_d0(c_d0), .c_be0(c_be0), .c_d1(c_d1), .c_be1(c_be1),
        .raddr(raddr), .rword_lo(rword_lo), .rword_hi(rword_hi)
    );

    qdrb2_rd_pipe #(.AW(AW), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .addr(addr),
        .raddr(raddr), .rword_lo(rword_lo), .rword_hi(rword_hi),
        .rdata(rdata), .rd_oe(rd_oe)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rd_oe);

    // R2
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel_n |-> ##2 rd_oe);

    // R7
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_n |-> ##2 !rd_oe);
endmodule

// File: tb/sim_qdrb2_sram.sv
`timescale 1ns/1ps
module sim_qdrb2_sram;
    localparam int AW = 4, LANES = 2, LB = 9, W = 18, DEPTH = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n, rd_sel_n, wr_sel_n, rd_oe;
    logic [AW-1:0]    addr;
    logic [W-1:0]     wdata, rdata;
    logic [LANES-1:0] bw_n;

    qdrb2_sram #(.AW(AW), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rd_oe(rd_oe)
    );

    logic [W-1:0] refm [DEPTH];
    int           nchk = 0, nfail = 0;
    bit           done = 0;
    bit           exp_v = 0;
    logic [W-1:0] exp_lo, exp_hi;
    string        exp_tag = "R2";

    function automatic logic [W-1:0] merge(input logic [W-1:0] o, input logic [W-1:0] n,
                                           input logic [LANES-1:0] mask_n);
        logic [W-1:0] r = o;
        for (int l = 0; l < LANES; l++)
            if (!mask_n[l]) r[l*LB +: LB] = n[l*LB +: LB];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle; entered and left 1 ns after a falling edge.
    task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wa, input logic [W-1:0] d0,
                       input logic [LANES-1:0] b0, input logic [W-1:0] d1,
                       input logic [LANES-1:0] b1, input string tag);
        rd_sel_n = !rd; wr_sel_n = !wr; addr = ra; wdata = d0; bw_n = b0;
        @(posedge clk); #1;
        chk(exp_v ? "R2" : "R7", W'(rd_oe), W'(exp_v));
        chk(exp_v ? {exp_tag, "/R2"} : "R7", rdata, exp_v ? exp_lo : '0);
        addr = wa; wdata = d1; bw_n = b1;
        @(negedge clk); #1;
        chk(exp_v ? {exp_tag, "/R3"} : "R7", rdata, exp_v ? exp_hi : '0);
        if (wr) begin
            refm[wa] = merge(refm[wa], d0, b0);
            refm[AW'(wa + 1'b1)] = merge(refm[AW'(wa + 1'b1)], d1, b1);
        end
        exp_v = rd;
        if (rd) begin
            exp_lo  = refm[ra];
            exp_hi  = refm[AW'(ra + 1'b1)];
            exp_tag = tag;
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, AW'($urandom), 0, AW'($urandom), W'($urandom), 2'b00, W'($urandom), 2'b00, tag);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) refm[i] = '0;
        rst_n = 0; rd_sel_n = 0; wr_sel_n = 0; addr = '0; wdata = '1; bw_n = '0;
        repeat (4) @(negedge clk);
        #1;
        // R1: quiet during reset
        chk("R1", W'(rd_oe), '0);
        chk("R1", rdata, '0);
        rst_n = 1;
        rd_sel_n = 1; wr_sel_n = 1;
        idle("R1");
        // R1: cleared array
        cyc(1, 4'd6, 0, 4'd0, '0, 2'b11, '0, 2'b11, "R1");
        idle("R7");
        // R4 basic write then read
        cyc(0, 4'd9, 1, 4'd3, 18'h1A5A5, 2'b00, 18'h25A5A, 2'b00, "R4");
        cyc(1, 4'd3, 0, 4'd0, '0, 2'b11, '0, 2'b11, "R4");
        // R5 lane masks differ per word
        cyc(0, 4'd0, 1, 4'd3, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01, "R5");
        cyc(1, 4'd3, 0, 4'd0, '0, 2'b11, '0, 2'b11, "R5");
        // R6 read and write to same address at one edge, partial masks
        cyc(1, 4'd7, 1, 4'd7, 18'h0BEEF, 2'b01, 18'h2CAFE, 2'b00, "R6");
        // R6 write followed directly by read
        cyc(0, 4'd0, 1, 4'd10, 18'h11111, 2'b00, 18'h22222, 2'b10, "R6");
        cyc(1, 4'd10, 1, 4'd11, 18'h33333, 2'b00, 18'h04444, 2'b00, "R6");
        cyc(1, 4'd11, 0, 4'd0, '0, 2'b11, '0, 2'b11, "R6");
        // R9 wrap at top address
        cyc(0, 4'd0, 1, 4'd15, 18'h3C3C3, 2'b00, 18'h15555, 2'b00, "R9");
        cyc(1, 4'd15, 0, 4'd0, '0, 2'b11, '0, 2'b11, "R9");
        // R8 deselected ports ignore address and data
        cyc(0, 4'd15, 0, 4'd15, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, "R8");
        cyc(1, 4'd15, 0, 4'd0, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, "R8");
        idle("R7");
        // random mix, many collisions in a narrow window
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] ra, wa;
            bit narrow;
            narrow = ($urandom % 2) == 0;
            ra = narrow ? AW'($urandom % 4) : AW'($urandom);
            wa = narrow ? AW'($urandom % 4) : AW'($urandom);
            cyc(($urandom % 3) != 0, ra, ($urandom % 3) != 0, wa,
                W'($urandom), LANES'($urandom), W'($urandom), LANES'($urandom), "R6");
        end
        idle("R7");
        idle("R7");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule